// File: doc/BRIEF.md
# Burst Column Sequencer

This block drives the data side of a single synchronous DRAM bank while a burst access is in progress. A one-cycle read or write start pulse, together with a start column, captures the burst setup: length code, ordering (linear wrap or XOR), and read latency of 2 or 3 cycles. From the following cycle on, the block presents one column address per cycle. For writes it raises a per-lane write enable. For reads it delivers a data-valid strobe and per-lane output enables, delayed by the captured latency.

Per-lane masking follows two timings. A write mask acts in the cycle it is driven. A read mask gates the output enable two cycles after it is driven. A full-page burst walks the whole page and wraps at its end until it is stopped. A burst can end in three ways: it completes, it is terminated, or the bank is precharged. A new start pulse during a burst cuts the old burst short and starts the new one. The block holds no array storage. The surrounding bank logic uses its strobes and addresses to steer data.

Top module: `burst_column_sequencer`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises with no start pulse, colValid, rdValid, rdOe and wrEn are all zero.
- R2: The burst length code blSel sets the number of beats: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives full page. Codes 3'b100 to 3'b110 give 1 beat. A start pulse in cycle c places beat k on colAddr, with colValid high, in cycle c+1+k.
- R3: When interleave is 0 and the length L is 1 to 8, beat k addresses (startCol with its low log2(L) bits replaced by (startCol+k) mod L).
- R4: When interleave is 1 and the length L is 1 to 8, beat k addresses (startCol with its low log2(L) bits replaced by those bits XOR k).
- R5: A full-page burst addresses startCol+k modulo 2^COL_W for every beat, whatever the interleave setting. It continues until stopBurst or precharge ends it.
- R6: For a read started in cycle c, rdValid is high in cycle c+CL+k for each beat k. CL is 3 when casLat3 was 1 at the start pulse and 2 otherwise.
- R7: During a write beat, wrEn[b] equals the inverse of maskIn[b] in the same cycle. Outside write beats, wrEn is zero.
- R8: rdOe[b] in cycle n equals rdValid in cycle n AND NOT maskIn[b] from cycle n-2.
- R9: stopBurst high in cycle n, with no start pulse in that cycle, makes cycle n the last beat. Read beats issued up to cycle n still produce rdValid at their latency.
- R10: precharge high in cycle n ends the burst after cycle n in the same way as R9. It also overrides a start pulse in the same cycle, so that no burst starts. stopBurst in the same cycle as a start pulse has no effect, and the new burst runs.
- R11: A start pulse during a burst ends the old burst. The new burst's beat 0, at the new column, appears in the next cycle.
- R12: blSel, interleave, casLat3 and startCol are captured only at a start pulse. Changing them during a burst alters neither the addresses, the beat count nor the read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdStart | input | 1 | Read burst start pulse; wins over wrStart |
| wrStart | input | 1 | Write burst start pulse |
| stopBurst | input | 1 | Burst terminate request |
| precharge | input | 1 | Bank precharge; ends the burst, overrides a start |
| startCol | input | COL_W | Start column of the burst |
| blSel | input | 3 | Burst length code (see R2) |
| interleave | input | 1 | 1 = XOR beat ordering, 0 = linear wrap |
| casLat3 | input | 1 | 1 = read latency 3, 0 = read latency 2 |
| maskIn | input | MASK_W | Per-lane mask |
| colAddr | output | COL_W | Column address of the current beat |
| colValid | output | 1 | A beat is present this cycle |
| rdValid | output | 1 | Read data for a beat is on the bus this cycle |
| rdOe | output | MASK_W | Per-lane read output enable |
| wrEn | output | MASK_W | Per-lane write enable |

## Verification
The results fall due at different times after a start pulse in cycle c. Beat k's address and write enable belong to cycle c+1+k. Read valid for the same beat lands CL-1 cycles after that address. A read output enable reflects the mask driven two cycles before. The bench drives inputs on the falling edge and checks each cycle's outputs shortly after. For every cycle it computes the expected values from a beat function of the cycle number, shifted by CL-1 for read valid and by two for the read mask. Every run also scrambles the setup inputs after the start pulse, so the capture rule is checked alongside the sweeps.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  // Burst length code that selects a full-page burst.
  localparam logic [2:0] BL_FULL = 3'b111;

  // Strobes handed from the control to the datapath.
  typedef struct packed {
    logic rdBeat;
    logic wrBeat;
    logic interleave;
    logic fullPage;
    logic cl3;
  } seqStrobes_t;
endpackage

// File: rtl/bsq_ctrl.sv
module bsq_ctrl
  import bsq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rdStart,
  input  logic             wrStart,
  input  logic             stopBurst,
  input  logic             precharge,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       blSel,
  input  logic             interleave,
  input  logic             casLat3,
  output seqStrobes_t      strb,
  output logic [COL_W-1:0] beatIdx,
  output logic [COL_W-1:0] baseCol,
  output logic [COL_W-1:0] lenMask
);
  logic             active;
  logic             isWrite;
  logic [COL_W-1:0] cnt;
  logic [COL_W-1:0] baseR;
  logic [2:0]       blR;
  logic             ilR;
  logic             clR;
  logic             fullPage;
  logic             lastBeat;
  logic             anyStart;

  assign anyStart = rdStart | wrStart;
  assign fullPage = (blR == BL_FULL);

  always_comb begin
    case (blR)
      3'b001:  lenMask = COL_W'(1);
      3'b010:  lenMask = COL_W'(3);
      3'b011:  lenMask = COL_W'(7);
      BL_FULL: lenMask = {COL_W{1'b1}};
      default: lenMask = '0;
    endcase
  end

  assign lastBeat = !fullPage && (cnt == lenMask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      isWrite <= 1'b0;
      cnt     <= '0;
      baseR   <= '0;
      blR     <= '0;
      ilR     <= 1'b0;
      clR     <= 1'b0;
    end else if (precharge) begin
      active <= 1'b0;
    end else if (anyStart) begin
      active  <= 1'b1;
      isWrite <= !rdStart;
      cnt     <= '0;
      baseR   <= startCol;
      blR     <= blSel;
      ilR     <= interleave;
      if (rdStart) clR <= casLat3;
    end else if (stopBurst) begin
      active <= 1'b0;
    end else if (active) begin
      if (lastBeat) active <= 1'b0;
      else          cnt    <= cnt + COL_W'(1);
    end
  end

  assign strb.rdBeat     = active & !isWrite;
  assign strb.wrBeat     = active & isWrite;
  assign strb.interleave = ilR;
  assign strb.fullPage   = fullPage;
  assign strb.cl3        = clR;
  assign beatIdx         = cnt;
  assign baseCol         = baseR;

  // R2
  beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !fullPage) |-> (cnt <= lenMask));

  // R10
  pch_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    precharge |=> !active);

  // R6
  rd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStart && !precharge) |=> (strb.rdBeat && cnt == '0));

  // R9
  term_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stopBurst && !anyStart) |=> !active);
endmodule

// File: rtl/bsq_dpath.sv
module bsq_dpath
  import bsq_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MASK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobes_t       strb,
  input  logic [COL_W-1:0]  beatIdx,
  input  logic [COL_W-1:0]  baseCol,
  input  logic [COL_W-1:0]  lenMask,
  input  logic [MASK_W-1:0] maskIn,
  output logic [COL_W-1:0]  colAddr,
  output logic              colValid,
  output logic              rdValid,
  output logic [MASK_W-1:0] rdOe,
  output logic [MASK_W-1:0] wrEn
);
  localparam int RD_DEPTH = 2;

  logic [COL_W-1:0]  linSum;
  logic [COL_W-1:0]  seqLow;
  logic [COL_W-1:0]  xorLow;
  logic [RD_DEPTH-1:0] rdPipe;
  logic [MASK_W-1:0] maskD1;
  logic [MASK_W-1:0] maskD2;

  assign linSum = baseCol + beatIdx;
  assign seqLow = linSum & lenMask;
  assign xorLow = (baseCol ^ beatIdx) & lenMask;

  always_comb begin
    if (strb.fullPage) colAddr = linSum;
    else colAddr = (baseCol & ~lenMask) | (strb.interleave ? xorLow : seqLow);
  end

  assign colValid = strb.rdBeat | strb.wrBeat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdPipe <= '0;
      maskD1 <= '0;
      maskD2 <= '0;
    end else begin
      rdPipe <= {rdPipe[RD_DEPTH-2:0], strb.rdBeat};
      maskD1 <= maskIn;
      maskD2 <= maskD1;
    end
  end

  assign rdValid = strb.cl3 ? rdPipe[1] : rdPipe[0];

  for (genvar b = 0; b < MASK_W; b++) begin : g_lane
    assign rdOe[b] = rdValid & ~maskD2[b];
    assign wrEn[b] = strb.wrBeat & ~maskIn[b];
  end

  // R2
  one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({strb.rdBeat, strb.wrBeat}) <= 1);

  // R6
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |-> ($past(strb.rdBeat) || $past(strb.rdBeat, 2)));
endmodule

// File: rtl/burst_column_sequencer.sv
module burst_column_sequencer
  import bsq_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MASK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdStart,
  input  logic              wrStart,
  input  logic              stopBurst,
  input  logic              precharge,
  input  logic [COL_W-1:0]  startCol,
  input  logic [2:0]        blSel,
  input  logic              interleave,
  input  logic              casLat3,
  input  logic [MASK_W-1:0] maskIn,
  output logic [COL_W-1:0]  colAddr,
  output logic              colValid,
  output logic              rdValid,
  output logic [MASK_W-1:0] rdOe,
  output logic [MASK_W-1:0] wrEn
);
  seqStrobes_t      strb;
  logic [COL_W-1:0] beatIdx;
  logic [COL_W-1:0] baseCol;
  logic [COL_W-1:0] lenMask;

  bsq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rdStart(rdStart), .wrStart(wrStart),
    .stopBurst(stopBurst), .precharge(precharge), .startCol(startCol),
    .blSel(blSel), .interleave(interleave), .casLat3(casLat3),
    .strb(strb), .beatIdx(beatIdx), .baseCol(baseCol), .lenMask(lenMask)
  );

  bsq_dpath #(.COL_W(COL_W), .MASK_W(MASK_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .beatIdx(beatIdx),
    .baseCol(baseCol), .lenMask(lenMask), .maskIn(maskIn),
    .colAddr(colAddr), .colValid(colValid), .rdValid(rdValid),
    .rdOe(rdOe), .wrEn(wrEn)
  );
endmodule

// File: tb/test_burst_column_sequencer.sv
module test_burst_column_sequencer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rdStart, wrStart, stopBurst, precharge;
  logic [7:0] startCol;
  logic [2:0] blSel;
  logic       interleave, casLat3;
  logic [1:0] maskIn;
  logic [7:0] colAddr;
  logic       colValid, rdValid;
  logic [1:0] rdOe, wrEn;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Parameters of the run in progress, used by the beat function.
  int       gStop, gRs, gLen, gSeed;
  bit       gPch, gIl;
  bit [7:0] gSt, gRsCol;

  always #4 clk = ~clk;

  burst_column_sequencer i_burst_column_sequencer (
    .clk(clk), .rst_n(rst_n), .rdStart(rdStart), .wrStart(wrStart),
    .stopBurst(stopBurst), .precharge(precharge), .startCol(startCol),
    .blSel(blSel), .interleave(interleave), .casLat3(casLat3),
    .maskIn(maskIn), .colAddr(colAddr), .colValid(colValid),
    .rdValid(rdValid), .rdOe(rdOe), .wrEn(wrEn)
  );

  function automatic int blLen(bit [2:0] s);
    case (s)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic bit [7:0] expCol(bit [7:0] st, int len, bit il, int k);
    bit [7:0] m, low, kk;
    kk = 8'(k);
    if (len == 0) return st + kk;
    m = 8'(len - 1);
    low = il ? ((st ^ kk) & m) : ((st + kk) & m);
    return (st & ~m) | low;
  endfunction

  function automatic bit [1:0] mk(int i);
    if (i < 0) return 2'b00;
    return 2'((i * 3 + gSeed) ^ (i >> 2));
  endfunction

  // Beat expected in cycle c of the current run (command in cycle 0).
  function automatic void beatAt(int c, output bit v, output bit [7:0] col);
    int k;
    bit [7:0] base;
    v = 0; col = 0;
    if (c < 1) return;
    if (gStop >= 0 && c > gStop && !(gStop == 0 && !gPch)) return;
    if (gRs >= 0 && c > gRs) begin k = c - gRs - 1; base = gRsCol; end
    else begin k = c - 1; base = gSt; end
    if (gLen != 0 && k >= gLen) return;
    v = 1;
    col = expCol(base, gLen, gIl, k);
  endfunction

  task automatic chk(string tag, int cyc, logic [13:0] got, logic [13:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s cycle %0d: got v=%b col=%h rv=%b oe=%b we=%b exp v=%b col=%h rv=%b oe=%b we=%b",
               tag, cyc, got[13], got[12:5], got[4], got[3:2], got[1:0],
               exp[13], exp[12:5], exp[4], exp[3:2], exp[1:0]);
    end
  endtask

  function automatic logic [13:0] gotVec();
    return {colValid, colValid ? colAddr : 8'h00, rdValid, rdOe, wrEn};
  endfunction

  task automatic idle(int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      rdStart = 0; wrStart = 0; stopBurst = 0; precharge = 0; maskIn = 0;
    end
  endtask

  task automatic runSeq(string tag, bit isWr, bit [2:0] bl, bit il, bit cl3,
                        bit [7:0] st, int stopCyc, bit usePch, int rsCyc,
                        bit [7:0] rsCol, int nCyc, int seed);
    int cl;
    gStop = stopCyc; gPch = usePch; gRs = rsCyc; gRsCol = rsCol;
    gSt = st; gLen = blLen(bl); gIl = (gLen == 0) ? 1'b0 : il; gSeed = seed;
    cl = cl3 ? 3 : 2;
    for (int i = 0; i < nCyc; i++) begin
      bit v, rv;
      bit [7:0] col, rcol;
      bit cmd;
      @(negedge clk);
      cmd = (i == 0) || (i == rsCyc);
      rdStart    = !isWr && cmd;
      wrStart    = isWr && cmd;
      startCol   = (i == rsCyc) ? rsCol : (cmd ? st : ~st);
      // R12: setup inputs scrambled outside command cycles
      blSel      = cmd ? bl : (bl ^ 3'b011);
      interleave = cmd ? il : !il;
      casLat3    = cmd ? cl3 : !cl3;
      stopBurst  = !usePch && (i == stopCyc);
      precharge  = usePch && (i == stopCyc);
      maskIn     = mk(i);
      #1;
      beatAt(i, v, col);
      beatAt(i - cl + 1, rv, rcol);
      rv = rv && !isWr;
      chk(tag, i, gotVec(),
          {v, v ? col : 8'h00, rv, rv ? ~mk(i - 2) : 2'b00,
           (isWr && v) ? ~mk(i) : 2'b00});
    end
    idle(3);
  endtask

  initial begin
    rst_n = 0; rdStart = 0; wrStart = 0; stopBurst = 0; precharge = 0;
    startCol = 0; blSel = 0; interleave = 0; casLat3 = 0; maskIn = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 in reset", -1, gotVec(), 14'h0);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 after reset", 0, gotVec(), 14'h0);

    // Read sweep over length, ordering, latency and start column.
    for (int b = 0; b < 4; b++)
      for (int il = 0; il < 2; il++)
        for (int c = 0; c < 2; c++)
          for (int s = 0; s < 3; s++) begin
            bit [7:0] st;
            st = (s == 0) ? 8'h00 : (s == 1) ? 8'h06 : 8'hFB;
            runSeq("R2 R3 R4 R6 R8 R12 read sweep", 0, 3'(b), il[0], c[0],
                   st, -1, 0, -1, 0, blLen(3'(b)) + 6, b + s);
          end

    // Write sweep.
    for (int b = 0; b < 4; b++)
      for (int il = 0; il < 2; il++)
        for (int s = 0; s < 3; s++) begin
          bit [7:0] st;
          st = (s == 0) ? 8'h03 : (s == 1) ? 8'h0D : 8'hF2;
          runSeq("R2 R3 R4 R7 R12 write sweep", 1, 3'(b), il[0], 0,
                 st, -1, 0, -1, 0, blLen(3'(b)) + 4, il + s);
        end

    runSeq("R2 reserved code", 0, 3'b101, 0, 1, 8'h21, -1, 0, -1, 0, 7, 1);
    runSeq("R5 R9 full-page read wrap", 0, 3'b111, 0, 1, 8'hFC, 9, 0, -1, 0, 16, 2);
    runSeq("R5 R10 full-page write precharge", 1, 3'b111, 1, 0, 8'h7E, 6, 1, -1, 0, 10, 3);
    runSeq("R9 terminate BL8 read", 0, 3'b011, 0, 0, 8'h40, 3, 0, -1, 0, 10, 0);
    runSeq("R10 precharge BL8 write", 1, 3'b011, 1, 0, 8'h55, 4, 1, -1, 0, 10, 2);
    runSeq("R11 restart read", 0, 3'b010, 1, 1, 8'h10, -1, 0, 2, 8'h2D, 10, 1);
    runSeq("R11 restart write", 1, 3'b011, 0, 0, 8'h33, -1, 0, 5, 8'h9E, 15, 3);
    runSeq("R10 precharge beats start", 0, 3'b010, 0, 0, 8'h08, 0, 1, -1, 0, 6, 0);
    runSeq("R10 terminate loses to start", 0, 3'b010, 0, 1, 8'h08, 0, 0, -1, 0, 9, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule